// File: doc/BRIEF.md
# Address-Range Access Watchpoint Unit

This block sits beside a memory arbiter and watches every access it grants. It holds a small bank of watchpoints. Each one has its own address window, its own set of allowed operation types and its own set of allowed clients. When an access falls inside a window and passes both filters, that watchpoint records what it saw. It keeps the clients involved, the address, the operation, the lowest-numbered offending client and the transfer size. It also raises its own interrupt bit.

Software reads the records and the status through a small register port. The read data is combinational and writes take effect at the clock edge. Each watchpoint keeps its first record until software writes its re-arm register. The interrupt bits are cleared on their own, through a write-one-to-clear register. A mask register decides which interrupt bits can drive the single interrupt line.

Register map, by word address. Watchpoint w uses the 16 words starting at w*16:
- Offset 0: start address.
- Offset 1: end address (exclusive).
- Offset 2: operation mask.
- Offset 3: client mask.
- Offsets 4 to 8: captured clients, captured address, captured operation, captured first client and captured size.
- Offset 9: re-arm (write-only).
- Offset 10: the captured flag in bit 0.

The shared registers are:
- 0xF0: interrupt mask.
- 0xF1: raw status.
- 0xF2: masked status.
- 0xF3: interrupt acknowledge (write-only).

Top module: `addr_watch`

## Requirements
- R1: After reset every register reads zero, no watchpoint holds a record, and `irq` is low.
- R2: An access matches a watchpoint only when start <= `acc_addr` < end. An address equal to the end address does not match, and an address equal to the start address does.
- R3: An access matches only when `acc_op` shares a set bit with the watchpoint's operation mask (bit 0 = read, bit 1 = write). Otherwise it is ignored.
- R4: An access matches only when `acc_clients` (bit i = client i) shares a set bit with the watchpoint's client mask. Otherwise it is ignored.
- R5: On a match with no record held, the watchpoint stores the following and sets its captured flag:
  - the clients `acc_clients & client_mask` at offset 4;
  - the address at offset 5;
  - `acc_op` at offset 6;
  - the index of the lowest set bit of those clients at offset 7;
  - `acc_size` at offset 8.
- R6: While a record is held, further matches leave all capture registers unchanged. A write of any value to offset 9 clears the captured flag, and the next match is then recorded.
- R7: A capture sets raw status bit w (register 0xF1). The bit stays set until a write to 0xF3 with bit w set. Writing 0 to bit w has no effect.
- R8: Masked status (0xF2 and `intr_masked`) equals raw status AND interrupt mask (0xF0, bit w enables watchpoint w). `irq` is high exactly when any masked bit is set.
- R9: All watchpoints evaluate the same access independently, and several may capture in the same cycle.
- R10: When `acc_valid` is low, no watchpoint captures, whatever the other access inputs hold.
- R11: A match in the same cycle as a re-arm write to that watchpoint is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW (32) | Access address |
| acc_op | input | 2 | Operation: bit 0 read, bit 1 write |
| acc_clients | input | NCL (16) | Clients taking part in the access |
| acc_size | input | SZW (8) | Access size |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Register read data (combinational) |
| intr_masked | output | NWP (4) | Masked interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- At most one register write happens per cycle.
- The re-arm and acknowledge strobes are visible only as writes to their decoded addresses.

From this they can reason about record holding and sticky status purely from the write port and the access strobe. The stimulus issues register writes and accesses from separate, non-overlapping tasks. The one exception is the single deliberate cycle where a re-arm and a matching access coincide. Every access uses a single-cycle `acc_valid` pulse aligned to a falling edge, so each capture is tied to exactly one clock edge.

// File: rtl/addr_watch.sv
module addr_watch #(
  parameter int NWP = 4,
  parameter int AW  = 32,
  parameter int NCL = 16,
  parameter int SZW = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_addr,
  input  logic [1:0]     acc_op,
  input  logic [NCL-1:0] acc_clients,
  input  logic [SZW-1:0] acc_size,
  input  logic           reg_we,
  input  logic [7:0]     reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic [NWP-1:0] intr_masked,
  output logic           irq
);
  localparam int CLW = $clog2(NCL);
  localparam logic [7:0] GBASE = 8'hF0;

  logic [AW-1:0]  first_q   [NWP];
  logic [AW-1:0]  last_q    [NWP];
  logic [1:0]     opm_q     [NWP];
  logic [NCL-1:0] clm_q     [NWP];
  logic [NCL-1:0] cap_cl_q  [NWP];
  logic [AW-1:0]  cap_addr_q[NWP];
  logic [1:0]     cap_op_q  [NWP];
  logic [CLW-1:0] cap_first_q[NWP];
  logic [SZW-1:0] cap_size_q[NWP];
  logic [NWP-1:0] cap_vld_q, raw_q, imask_q;
  logic [NWP-1:0] hit, take, rearm;
  logic [NWP-1:0] ack_bits;

  function automatic logic [CLW-1:0] lowest_set(input logic [NCL-1:0] v);
    lowest_set = '0;
    for (int i = NCL - 1; i >= 0; i--)
      if (v[i]) lowest_set = CLW'(i);
  endfunction

  always_comb begin
    for (int w = 0; w < NWP; w++) begin
      hit[w]   = acc_valid && (acc_addr >= first_q[w]) && (acc_addr < last_q[w]) &&
                 |(acc_op & opm_q[w]) && |(acc_clients & clm_q[w]);
      rearm[w] = reg_we && (reg_addr[7:4] == 4'(w)) && (reg_addr[3:0] == 4'd9);
      take[w]  = hit[w] && !cap_vld_q[w] && !rearm[w];
    end
  end

  assign ack_bits    = (reg_we && reg_addr == GBASE + 8'd3) ? reg_wdata[NWP-1:0] : '0;
  assign intr_masked = raw_q & imask_q;
  assign irq         = |intr_masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWP; w++) begin
        first_q[w]     <= '0;
        last_q[w]      <= '0;
        opm_q[w]       <= '0;
        clm_q[w]       <= '0;
        cap_cl_q[w]    <= '0;
        cap_addr_q[w]  <= '0;
        cap_op_q[w]    <= '0;
        cap_first_q[w] <= '0;
        cap_size_q[w]  <= '0;
      end
      cap_vld_q <= '0;
    end else begin
      for (int w = 0; w < NWP; w++) begin
        if (reg_we && reg_addr[7:4] == 4'(w)) begin
          case (reg_addr[3:0])
            4'd0: first_q[w] <= reg_wdata[AW-1:0];
            4'd1: last_q[w]  <= reg_wdata[AW-1:0];
            4'd2: opm_q[w]   <= reg_wdata[1:0];
            4'd3: clm_q[w]   <= reg_wdata[NCL-1:0];
            default: ;
          endcase
        end
        if (rearm[w])
          cap_vld_q[w] <= 1'b0;
        else if (take[w]) begin
          cap_vld_q[w]   <= 1'b1;
          cap_cl_q[w]    <= acc_clients & clm_q[w];
          cap_addr_q[w]  <= acc_addr;
          cap_op_q[w]    <= acc_op;
          cap_first_q[w] <= lowest_set(acc_clients & clm_q[w]);
          cap_size_q[w]  <= acc_size;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      imask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~ack_bits) | take;
      if (reg_we && reg_addr == GBASE) imask_q <= reg_wdata[NWP-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      GBASE:        reg_rdata = DW'(imask_q);
      GBASE + 8'd1: reg_rdata = DW'(raw_q);
      GBASE + 8'd2: reg_rdata = DW'(intr_masked);
      default: begin
        for (int w = 0; w < NWP; w++) begin
          if (reg_addr[7:4] == 4'(w)) begin
            case (reg_addr[3:0])
              4'd0:  reg_rdata = DW'(first_q[w]);
              4'd1:  reg_rdata = DW'(last_q[w]);
              4'd2:  reg_rdata = DW'(opm_q[w]);
              4'd3:  reg_rdata = DW'(clm_q[w]);
              4'd4:  reg_rdata = DW'(cap_cl_q[w]);
              4'd5:  reg_rdata = DW'(cap_addr_q[w]);
              4'd6:  reg_rdata = DW'(cap_op_q[w]);
              4'd7:  reg_rdata = DW'(cap_first_q[w]);
              4'd8:  reg_rdata = DW'(cap_size_q[w]);
              4'd10: reg_rdata = DW'(cap_vld_q[w]);
              default: ;
            endcase
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/addr_watch_chk.sv
module addr_watch_chk #(
  parameter int NWP = 4,
  parameter int AW  = 32,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           acc_valid,
  input logic           reg_we,
  input logic [7:0]     reg_addr,
  input logic [DW-1:0]  reg_wdata,
  input logic           irq,
  input logic [NWP-1:0] cap_vld_q,
  input logic [NWP-1:0] raw_q,
  input logic [NWP-1:0] imask_q,
  input logic [NWP-1:0] rearm,
  input logic [AW-1:0]  cap_addr_q [NWP]
);
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(raw_q & imask_q));

  for (genvar w = 0; w < NWP; w++) begin : g_w
    a_r6_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vld_q[w] && !rearm[w] |=> $stable(cap_addr_q[w]));
    a_r7_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      raw_q[w] && !(reg_we && reg_addr == 8'hF3 && reg_wdata[w]) |=> raw_q[w]);
    a_r5_capture_raises_raw: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_vld_q[w]) |-> raw_q[w]);
    a_r10_idle_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid && !cap_vld_q[w] |=> !cap_vld_q[w]);
  end
endmodule

bind addr_watch addr_watch_chk #(.NWP(NWP), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq),
  .cap_vld_q(cap_vld_q), .raw_q(raw_q), .imask_q(imask_q), .rearm(rearm),
  .cap_addr_q(cap_addr_q)
);

// File: tb/addr_watch_bench.sv
module addr_watch_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_op = '0;
  logic [15:0] acc_clients = '0;
  logic [7:0]  acc_size = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  intr_masked;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] e;
    string       rq;
    bit          irqk;
  } item_t;
  item_t q[$];

  always #(CLK_P/2) clk = ~clk;

  addr_watch u_addr_watch (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_op(acc_op), .acc_clients(acc_clients), .acc_size(acc_size),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .intr_masked(intr_masked), .irq(irq)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] op,
                     input logic [15:0] cl, input logic [7:0] sz, input bit v);
    acc_valid = v; acc_addr = a; acc_op = op; acc_clients = cl; acc_size = sz;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic rearm_and_acc(input logic [7:0] a, input logic [31:0] addr,
                               input logic [15:0] cl);
    reg_we = 1'b1; reg_addr = a; reg_wdata = '0;
    acc_valid = 1'b1; acc_addr = addr; acc_op = 2'b10; acc_clients = cl; acc_size = 8'h1;
    @(negedge clk);
    reg_we = 1'b0; acc_valid = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string rq);
    item_t it;
    reg_addr = a;
    it.a = a; it.e = e; it.rq = rq; it.irqk = 1'b0;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string rq);
    item_t it;
    it.a = reg_addr; it.e = {31'b0, e}; it.rq = rq; it.irqk = 1'b1;
    q.push_back(it);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.irqk ? {31'b0, irq} : reg_rdata;
        checks++;
        if (act !== it.e) begin
          errors++;
          $display("FAIL %s: %s addr %h got %h exp %h", it.rq,
                   it.irqk ? "irq" : "reg", it.a, act, it.e);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(8'h00, 32'h0, "R1");
    chk(8'h0A, 32'h0, "R1");
    chk(8'hF1, 32'h0, "R1");
    chk_irq(1'b0, "R1");

    wr(8'h00, 32'h1000);
    wr(8'h01, 32'h2000);
    wr(8'h02, 32'h2);
    wr(8'h03, 32'h00F0);
    wr(8'hF0, 32'h1);
    chk(8'h01, 32'h2000, "R2");

    acc(32'h0FFF, 2'b10, 16'h0010, 8'h4, 1'b1);
    chk(8'h0A, 32'h0, "R2");
    acc(32'h2000, 2'b10, 16'h0010, 8'h4, 1'b1);
    chk(8'h0A, 32'h0, "R2");
    acc(32'h1800, 2'b01, 16'h0010, 8'h4, 1'b1);
    chk(8'h0A, 32'h0, "R3");
    acc(32'h1800, 2'b10, 16'h0001, 8'h4, 1'b1);
    chk(8'h0A, 32'h0, "R4");
    acc(32'h1800, 2'b10, 16'h0010, 8'h4, 1'b0);
    chk(8'h0A, 32'h0, "R10");
    chk(8'hF1, 32'h0, "R10");

    acc(32'h1000, 2'b10, 16'h0161, 8'h20, 1'b1);
    chk(8'h0A, 32'h1, "R2");
    chk(8'h04, 32'h0060, "R5");
    chk(8'h05, 32'h1000, "R5");
    chk(8'h06, 32'h2, "R5");
    chk(8'h07, 32'h5, "R5");
    chk(8'h08, 32'h20, "R5");
    chk(8'hF1, 32'h1, "R7");
    chk(8'hF2, 32'h1, "R8");
    chk_irq(1'b1, "R8");

    acc(32'h1FFF, 2'b10, 16'h0080, 8'h4, 1'b1);
    chk(8'h05, 32'h1000, "R6");
    chk(8'h07, 32'h5, "R6");

    wr(8'hF3, 32'h0);
    chk(8'hF1, 32'h1, "R7");
    wr(8'hF3, 32'h1);
    chk(8'hF1, 32'h0, "R7");
    chk_irq(1'b0, "R8");
    chk(8'h0A, 32'h1, "R6");

    wr(8'h09, 32'h0);
    chk(8'h0A, 32'h0, "R6");
    acc(32'h1100, 2'b10, 16'h0010, 8'h2, 1'b1);
    chk(8'h05, 32'h1100, "R6");
    chk(8'h07, 32'h4, "R6");

    rearm_and_acc(8'h09, 32'h1200, 16'h0010);
    chk(8'h0A, 32'h0, "R11");
    chk(8'h05, 32'h1100, "R11");
    acc(32'h1300, 2'b10, 16'h0080, 8'h3, 1'b1);
    chk(8'h05, 32'h1300, "R11");
    chk(8'h07, 32'h7, "R5");

    wr(8'hF0, 32'h0);
    chk(8'hF1, 32'h1, "R8");
    chk(8'hF2, 32'h0, "R8");
    chk_irq(1'b0, "R8");

    wr(8'h10, 32'h1000);
    wr(8'h11, 32'h1400);
    wr(8'h12, 32'h3);
    wr(8'h13, 32'hFFFF);
    wr(8'h20, 32'h1300);
    wr(8'h21, 32'h1301);
    wr(8'h22, 32'h1);
    wr(8'h23, 32'h8000);
    wr(8'h09, 32'h0);
    wr(8'hF3, 32'hF);
    wr(8'hF0, 32'h4);
    acc(32'h1300, 2'b01, 16'h8001, 8'h8, 1'b1);
    chk(8'h0A, 32'h0, "R9");
    chk(8'h1A, 32'h1, "R9");
    chk(8'h14, 32'h8001, "R9");
    chk(8'h17, 32'h0, "R9");
    chk(8'h24, 32'h8000, "R9");
    chk(8'h27, 32'hF, "R9");
    chk(8'h28, 32'h8, "R9");
    chk(8'hF1, 32'h6, "R9");
    chk(8'hF2, 32'h4, "R8");
    chk_irq(1'b1, "R8");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule